// File: doc/BRIEF.md
# Gated IF Frequency Counter

This block measures the frequency of an intermediate-frequency signal so that seek logic can decide whether a station is locked. One of two logic-level inputs is picked, brought into the system clock domain, and its rising edges are counted while a gate window is open. The count is a saturating 20-bit value. An overflow flag is set when the count would pass all-ones.

In automatic mode the window is a whole number of 1 ms ticks: 1, 4, 16 or 64 of them. A free-running prescaler produces the ticks, and the window starts and ends on a tick. In manual mode the window is opened and closed by two separate software strobes. A start strobe clears the result and launches a measurement. The start strobe is ignored while a measurement is in progress. A done flag marks the end of the measurement and stays set until a readout acknowledge or the next start.

The counted input is sampled by the system clock. The system clock must therefore be more than twice the highest input rate: above 40 MHz for a 20 MHz input.

Top module: `ifreq_counter`

## Requirements
- R1: After reset `count` is 0, and `busy`, `done` and `overflow` are all 0.
- R2: A `start` pulse while `busy` is 0 clears `count`, `overflow` and `done` and sets `busy` on the same clock edge. `gate_sel` and `manual_mode` are captured on that edge.
- R3: In automatic mode (`manual_mode`=0), `gate_sel` picks the window length. The codes 0, 1, 2 and 3 give 1, 4, 16 and 64 ticks. One tick lasts TICK_DIV system clocks, which is 1 ms at the intended clock rate. The window opens on the first tick after start and lasts exactly that number of tick periods.
- R4: Only rising edges of the selected input that fall inside the window are counted. `src_sel`=0 selects `src_a` and `src_sel`=1 selects `src_b`.
- R5: In manual mode (`manual_mode`=1) a `man_open` pulse opens the window and a later `man_close` pulse closes it. `man_open` has no effect except while waiting to open, and `man_close` has no effect except while the window is open.
- R6: When the window closes, `done` rises and `busy` falls on the same edge. `done` is cleared by `read_ack` or by the next accepted start.
- R7: The count saturates at all ones (0xFFFFF for the default 20-bit width). An edge that arrives at saturation sets `overflow`.
- R8: A `start` pulse while `busy` is 1 is ignored. The measurement in progress is neither cleared nor restarted.
- R9: While the window is closed and no start is accepted, `count` holds its value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| src_sel | input | 1 | Input select: 0 = src_a, 1 = src_b |
| src_a | input | 1 | First counted signal, logic level |
| src_b | input | 1 | Second counted signal, logic level |
| gate_sel | input | 2 | Automatic window length code |
| manual_mode | input | 1 | 1 = software-controlled window |
| start | input | 1 | Start strobe, one clock |
| man_open | input | 1 | Manual window open strobe |
| man_close | input | 1 | Manual window close strobe |
| read_ack | input | 1 | Readout acknowledge, clears done |
| busy | output | 1 | Measurement in progress |
| done | output | 1 | Result ready |
| overflow | output | 1 | Count saturated |
| count | output | COUNT_W | Edge count (20 bits by default) |

## Verification
Assertions check the following on every cycle:
- the count holds while the window is closed (R9);
- the count steps by one per edge inside the window and stays pinned at saturation (R4, R7);
- busy and done are never both set, and both change together when the window closes (R6);
- a start pulse during a measurement cannot end it (R8).

Some behaviours can only be shown by the bench scenarios: the window length for each gate code, the choice of input, the manual open and close sequence, and the saturation result. The bench drives periodic inputs and compares the final counts with values computed from the window length and the input period.

// File: rtl/ifreq_pkg.sv
package ifreq_pkg;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_ARM,
    ST_AUTO,
    ST_MWAIT,
    ST_MOPEN
  } gate_state_t;

  // window length in ticks: code k -> 4^k
  function automatic logic [6:0] gate_ticks(input logic [1:0] code);
    return 7'(7'd1 << (2 * code));
  endfunction

endpackage

// File: rtl/ifreq_tick.sv
module ifreq_tick #(
  parameter int TICK_DIV = 100_000
) (
  input  logic clk,
  input  logic rst_n,
  output logic tick
);
  localparam int DIV_W = (TICK_DIV > 1) ? $clog2(TICK_DIV) : 1;
  localparam logic [DIV_W-1:0] LAST = DIV_W'(TICK_DIV - 1);

  logic [DIV_W-1:0] div_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) div_q <= '0;
    else if (div_q == LAST) div_q <= '0;
    else div_q <= div_q + 1'b1;
  end

  assign tick = (div_q == LAST);

endmodule

// File: rtl/ifreq_edge.sv
module ifreq_edge (
  input  logic clk,
  input  logic rst_n,
  input  logic src_sel,
  input  logic src_a,
  input  logic src_b,
  output logic rise
);
  logic picked;
  logic [2:0] sh_q;

  assign picked = src_sel ? src_b : src_a;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sh_q <= '0;
    else sh_q <= {sh_q[1:0], picked};
  end

  assign rise = sh_q[1] & ~sh_q[2];

endmodule

// File: rtl/ifreq_gate.sv
module ifreq_gate
  import ifreq_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic       tick,
  input  logic [1:0] gate_sel,
  input  logic       manual_mode,
  input  logic       start,
  input  logic       man_open,
  input  logic       man_close,
  input  logic       read_ack,
  output logic       gate_open,
  output logic       clear,
  output logic       busy,
  output logic       done
);
  gate_state_t state;
  logic [1:0]  sel_q;
  logic [6:0]  remain;
  logic        close_evt;

  assign busy      = (state != ST_IDLE);
  assign clear     = start && (state == ST_IDLE);
  assign close_evt = ((state == ST_AUTO) && tick && (remain == '0)) ||
                     ((state == ST_MOPEN) && man_close);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state     <= ST_IDLE;
      sel_q     <= '0;
      remain    <= '0;
      gate_open <= 1'b0;
      done      <= 1'b0;
    end else begin
      if (read_ack) done <= 1'b0;
      case (state)
        ST_IDLE: if (start) begin
          done  <= 1'b0;
          sel_q <= gate_sel;
          state <= manual_mode ? ST_MWAIT : ST_ARM;
        end
        ST_ARM: if (tick) begin
          gate_open <= 1'b1;
          remain    <= gate_ticks(sel_q) - 7'd1;
          state     <= ST_AUTO;
        end
        ST_AUTO: if (tick) begin
          if (remain == '0) begin
            gate_open <= 1'b0;
            done      <= 1'b1;
            state     <= ST_IDLE;
          end else begin
            remain <= remain - 7'd1;
          end
        end
        ST_MWAIT: if (man_open) begin
          gate_open <= 1'b1;
          state     <= ST_MOPEN;
        end
        ST_MOPEN: if (man_close) begin
          gate_open <= 1'b0;
          done      <= 1'b1;
          state     <= ST_IDLE;
        end
        default: state <= ST_IDLE;
      endcase
    end
  end

  // R6: result-ready and in-progress are exclusive
  a_r6_done_excl: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({busy, done}));
  // R6: closing the window raises done and drops busy together
  a_r6_close_done: assert property (@(posedge clk) disable iff (!rst_n)
    close_evt |=> (done && !busy && !gate_open));
  // R8: a measurement can only end through a window close
  a_r8_start_ignored: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && !close_evt) |=> busy);
  // R3: the automatic window only opens on a tick
  a_r3_open_on_tick: assert property (@(posedge clk) disable iff (!rst_n)
    ((state == ST_ARM) && !tick) |=> !gate_open);

endmodule

// File: rtl/ifreq_accum.sv
module ifreq_accum #(
  parameter int COUNT_W = 20
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               clear,
  input  logic               gate_open,
  input  logic               rise,
  output logic [COUNT_W-1:0] count,
  output logic               overflow
);
  localparam logic [COUNT_W-1:0] CNT_MAX = '1;

  // next value: saturating increment, flag reports a lost edge
  function automatic logic [COUNT_W:0] sat_inc(input logic [COUNT_W-1:0] v);
    if (v == CNT_MAX) return {1'b1, CNT_MAX};
    return {1'b0, v + 1'b1};
  endfunction

  logic [COUNT_W:0] nxt;
  assign nxt = sat_inc(count);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      count    <= '0;
      overflow <= 1'b0;
    end else if (clear) begin
      count    <= '0;
      overflow <= 1'b0;
    end else if (gate_open && rise) begin
      count <= nxt[COUNT_W-1:0];
      if (nxt[COUNT_W]) overflow <= 1'b1;
    end
  end

  // R9: closed window freezes the result
  a_r9_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (!gate_open && !clear) |=> $stable(count));
  // R7: saturation is sticky until a new start
  a_r7_saturate: assert property (@(posedge clk) disable iff (!rst_n)
    ((count == CNT_MAX) && !clear) |=> (count == CNT_MAX));
  // R7: overflow only ever accompanies a saturated count
  a_r7_ovf_max: assert property (@(posedge clk) disable iff (!rst_n)
    overflow |-> (count == CNT_MAX));
  // R4: each in-window edge below saturation adds one
  a_r4_step: assert property (@(posedge clk) disable iff (!rst_n)
    (gate_open && rise && !clear && (count != CNT_MAX)) |=> (count == $past(count) + 1'b1));

endmodule

// File: rtl/ifreq_counter.sv
module ifreq_counter #(
  parameter int TICK_DIV = 100_000,
  parameter int COUNT_W  = 20
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               src_sel,
  input  logic               src_a,
  input  logic               src_b,
  input  logic [1:0]         gate_sel,
  input  logic               manual_mode,
  input  logic               start,
  input  logic               man_open,
  input  logic               man_close,
  input  logic               read_ack,
  output logic               busy,
  output logic               done,
  output logic               overflow,
  output logic [COUNT_W-1:0] count
);
  logic tick;
  logic rise;
  logic gate_open;
  logic clear;

  ifreq_tick #(.TICK_DIV(TICK_DIV)) u_tick (
    .clk(clk), .rst_n(rst_n), .tick(tick)
  );

  ifreq_edge u_edge (
    .clk(clk), .rst_n(rst_n), .src_sel(src_sel),
    .src_a(src_a), .src_b(src_b), .rise(rise)
  );

  ifreq_gate u_gate (
    .clk(clk), .rst_n(rst_n), .tick(tick), .gate_sel(gate_sel),
    .manual_mode(manual_mode), .start(start), .man_open(man_open),
    .man_close(man_close), .read_ack(read_ack), .gate_open(gate_open),
    .clear(clear), .busy(busy), .done(done)
  );

  ifreq_accum #(.COUNT_W(COUNT_W)) u_accum (
    .clk(clk), .rst_n(rst_n), .clear(clear), .gate_open(gate_open),
    .rise(rise), .count(count), .overflow(overflow)
  );

  // R2: an accepted start leaves a cleared, running measurement
  a_r2_start_clears: assert property (@(posedge clk) disable iff (!rst_n)
    (start && !busy) |=> (busy && !done && (count == '0) && !overflow));

endmodule

// File: tb/ifreq_counter_test.sv
`timescale 1ns/1ps
module ifreq_counter_test;
  localparam int TDIV = 20;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic src_sel = 1'b0, src_a = 1'b0, src_b = 1'b0;
  logic [1:0] gate_sel = 2'd0;
  logic manual_mode = 1'b0, start = 1'b0, man_open = 1'b0;
  logic man_close = 1'b0, read_ack = 1'b0;
  logic busy, done, overflow;
  logic [19:0] count;
  logic busy_s, done_s, ovf_s;
  logic [7:0] count_s;

  int checks = 0, errors = 0, cycles = 0;
  int pa = 4, pb = 10, ca = 0, cb = 0;

  always #2.5 clk = ~clk;

  ifreq_counter #(.TICK_DIV(TDIV), .COUNT_W(20)) uut (
    .clk(clk), .rst_n(rst_n), .src_sel(src_sel), .src_a(src_a), .src_b(src_b),
    .gate_sel(gate_sel), .manual_mode(manual_mode), .start(start),
    .man_open(man_open), .man_close(man_close), .read_ack(read_ack),
    .busy(busy), .done(done), .overflow(overflow), .count(count));

  ifreq_counter #(.TICK_DIV(TDIV), .COUNT_W(8)) uut_sat (
    .clk(clk), .rst_n(rst_n), .src_sel(src_sel), .src_a(src_a), .src_b(src_b),
    .gate_sel(gate_sel), .manual_mode(manual_mode), .start(start),
    .man_open(man_open), .man_close(man_close), .read_ack(read_ack),
    .busy(busy_s), .done(done_s), .overflow(ovf_s), .count(count_s));

  // periodic test inputs, updated away from the active edge
  always @(negedge clk) begin
    ca = (ca + 1) % pa;
    cb = (cb + 1) % pb;
    src_a <= (ca < pa / 2);
    src_b <= (cb < pb / 2);
  end

  task automatic check(input string tag, input int act, input int exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
    end
  endtask

  task automatic pulse(ref logic sig);
    @(negedge clk) sig = 1'b1;
    @(negedge clk) sig = 1'b0;
  endtask

  task automatic wait_done();
    for (int i = 0; i < 5000 && !done; i++) @(negedge clk);
  endtask

  function automatic int win_ticks(input int code);
    case (code)
      0: return 1;
      1: return 4;
      2: return 16;
      default: return 64;
    endcase
  endfunction

  task automatic run_auto(input int code, input logic sel, input int period);
    gate_sel = 2'(code); src_sel = sel; manual_mode = 1'b0;
    repeat (6) @(negedge clk);
    pulse(start);
    check("R2 busy after start", busy, 1);
    check("R2 done cleared", done, 0);
    wait_done();
    check("R6 done at close", done, 1);
    check("R6 busy low at close", busy, 0);
    check($sformatf("R3/R4 count code %0d sel %0d", code, sel), count,
          win_ticks(code) * TDIV / period);
    repeat (30) @(negedge clk);
    check("R9 count held after close", count, win_ticks(code) * TDIV / period);
  endtask

  task automatic test_reset();
    check("R1 count", count, 0);
    check("R1 busy", busy, 0);
    check("R1 done", done, 0);
    check("R1 overflow", overflow, 0);
  endtask

  task automatic test_manual();
    logic [19:0] prev;
    manual_mode = 1'b1; src_sel = 1'b0; pa = 4;
    prev = count;
    pulse(man_open);                 // idle: ignored
    repeat (20) @(negedge clk);
    check("R5 open ignored when idle busy", busy, 0);
    check("R5 open ignored when idle count", count, prev);
    pulse(start);
    pulse(man_close);                // waiting: ignored
    repeat (20) @(negedge clk);
    check("R5 close ignored before open", busy, 1);
    check("R9 no count before open", count, 0);
    pulse(man_open);
    repeat (38) @(negedge clk);
    pulse(man_close);                // window of 40 clocks
    @(negedge clk);
    check("R5 manual done", done, 1);
    check("R5 manual count", count, 10);
    pulse(read_ack);
    check("R6 read_ack clears done", done, 0);
    check("R6 read_ack keeps count", count, 10);
  endtask

  task automatic test_busy_start();
    manual_mode = 1'b1;
    pulse(start);
    pulse(man_open);
    repeat (10) @(negedge clk);
    manual_mode = 1'b0; gate_sel = 2'd0;
    pulse(start);                    // would run a short auto gate if taken
    repeat (200) @(negedge clk);
    check("R8 still busy after ignored start", busy, 1);
    check("R8 no done after ignored start", done, 0);
    check("R8 count not cleared", (count > 40) ? 1 : 0, 1);
    pulse(man_close);
    @(negedge clk);
    check("R8 manual run completes", done, 1);
  endtask

  task automatic test_saturate();
    manual_mode = 1'b1; src_sel = 1'b0; pa = 2;
    repeat (4) @(negedge clk);
    pulse(start);
    pulse(man_open);
    repeat (598) @(negedge clk);
    pulse(man_close);                // 600 clocks, 300 edges
    @(negedge clk);
    check("R7 wide count", count, 300);
    check("R7 wide no overflow", overflow, 0);
    check("R7 narrow saturated", count_s, 255);
    check("R7 narrow overflow", ovf_s, 1);
    pulse(start);
    check("R2 start clears overflow", ovf_s, 0);
    check("R2 start clears count", count_s, 0);
    pulse(man_open);
    pulse(man_close);
    @(negedge clk);
    pa = 4;
  endtask

  initial begin
    repeat (3) @(negedge clk);
    test_reset();
    rst_n = 1'b1;
    repeat (3) @(negedge clk);
    run_auto(0, 1'b0, 4);
    run_auto(1, 1'b0, 4);
    run_auto(2, 1'b0, 4);
    run_auto(3, 1'b0, 4);
    run_auto(1, 1'b1, 10);
    run_auto(3, 1'b1, 10);
    test_manual();
    test_busy_start();
    test_saturate();
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  always @(posedge clk) begin
    cycles++;
    if (cycles > 150000) begin
      checks++; errors++;
      $display("FAIL watchdog: actual %0d cycles expected completion", cycles);
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

endmodule